// File: doc/BRIEF.md
# PHY Management Serial Controller

This block runs one serial management transaction to an external PHY each time software writes a 32-bit command word into it. Software composes the whole frame in that word: the start pattern, the operation code, the PHY and register addresses, the turnaround pattern and, for a write, the 16 data bits. The block first sends 32 preamble ones and then the command word, most significant bit first. It produces the management clock by dividing the system clock by one of four powers of two.

On a read the block releases the data line from the turnaround onward. It samples the 16 returning bits on rising management-clock edges and places them in the low half of the command register. At the end of every transaction it sets a done flag that software clears by reading it. A status register shows the live level of the data pin and whether the engine is idle. Nothing is driven on the management pins unless software has set the port enable bit.

Top module: `mdio_mgmt_top`

## Requirements
- R1: The management clock period is 8, 16, 32 or 64 system clocks for configuration field values 0, 1, 2 and 3 in bits 1:0 of register offset 1. The field is taken when a transaction starts. The clock rests low while idle.
- R2: Each transaction sends 32 ones followed by the 32 command bits, MSB first, for 64 management clock periods in all. The data line changes only on falling clock edges, so each bit is stable across its rising edge.
- R3: When command bits 29:28 equal 2 (read), the output enable is 0 from frame bit 46 onward, which is the first turnaround bit. The 16 bits seen on the rising edges of frame bits 48 to 63 are stored MSB first in command bits 15:0. Command bits 31:16 keep their written value.
- R4: For any other value of bits 29:28 (1 is the write code), the data line is driven for all 64 frame bits and the command register keeps the written word.
- R5: Bit 0 of the interrupt register (offset 3) is set in the cycle in which a transaction ends, exactly 64 management periods after the command write. It is cleared by a read of offset 3. If the read and the completion fall in the same cycle, the bit is set.
- R6: Status register (offset 2) bit 1 shows the present level of the data input pin. Bit 2 reads 1 when the engine is idle and 0 while a transaction runs.
- R7: A write to the command register (offset 4) while a transaction runs is ignored: the running frame and the stored word are unchanged.
- R8: While bit 0 of the control register (offset 0) is 0, command writes start nothing: the clock stays low, the output enable stays 0 and the done bit stays 0.
- R9: After reset, the control and configuration registers read 0, the done bit reads 0, the idle bit reads 1, and the clock and output enable are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line level seen at the pin |

## Verification
The read that clears the done bit and the transaction end that sets it can land in the same cycle. The bench provokes this by reading the interrupt register in every cycle of a transaction, so one of those reads coincides with the end. It expects exactly one read to return 1, and that read must come in the cycle right after the computed end cycle, 64 management periods after the command write. A bench PHY model checks the captured frame, the output-enable release and the clock period alongside, over directed and seeded random commands for all four dividers and both operations.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL = 3'd0,
    RA_CFG  = 3'd1,
    RA_STAT = 3'd2,
    RA_IRQ  = 3'd3,
    RA_CMD  = 3'd4
  } reg_addr_e;

  localparam logic [1:0] OP_READ = 2'b10;

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);

  localparam int CNT_W = BASE_LOG2 - 1 + (1 << SEL_W) - 1;

  logic [SEL_W-1:0] sel_q, sel_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             mdc_q, mdc_n;
  logic [CNT_W:0]   half_v, half_m1;
  logic             term;

  always_comb begin
    half_v  = (CNT_W+1)'(1) << (BASE_LOG2 - 1 + int'(sel_q));
    half_m1 = half_v - (CNT_W+1)'(1);
    term    = run && (cnt_q == half_m1[CNT_W-1:0]);
  end

  assign rise_tick = term & ~mdc_q;
  assign fall_tick = term & mdc_q;
  assign mdc       = mdc_q;

  always_comb begin
    sel_n = sel_q;
    cnt_n = cnt_q;
    mdc_n = mdc_q;
    if (start) begin
      sel_n = div_sel;
      cnt_n = '0;
      mdc_n = 1'b0;
    end else if (run) begin
      if (term) begin
        cnt_n = '0;
        mdc_n = ~mdc_q;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end else begin
      cnt_n = '0;
      mdc_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      sel_q <= sel_n;
      cnt_q <= cnt_n;
      mdc_q <= mdc_n;
    end
  end

  // R1
  mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdc_q) |-> $past(run));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
  parameter int PRE_LEN = 32,
  parameter int CMD_W   = 32,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done_pulse,
  output logic              is_read,
  output logic [DATA_W-1:0] cap_data,
  output logic              mdio_o,
  output logic              mdio_oe
);

  import mdio_mgmt_pkg::*;

  localparam int FRAME_LEN = PRE_LEN + CMD_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int DAT_IDX   = FRAME_LEN - DATA_W;
  localparam int REL_IDX   = DAT_IDX - 2;

  logic                 busy_q, busy_n;
  logic [IDX_W-1:0]     idx_q, idx_n;
  logic [FRAME_LEN-1:0] sh_q, sh_n;
  logic                 rd_q, rd_n;
  logic [DATA_W-1:0]    cap_q, cap_n;
  logic                 last;

  assign last       = (idx_q == IDX_W'(FRAME_LEN - 1));
  assign done_pulse = busy_q & fall_tick & last;
  assign busy       = busy_q;
  assign is_read    = rd_q;
  assign cap_data   = cap_q;
  assign mdio_o     = sh_q[FRAME_LEN-1];
  assign mdio_oe    = busy_q & (~rd_q | (idx_q < IDX_W'(REL_IDX)));

  always_comb begin
    busy_n = busy_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    rd_n   = rd_q;
    cap_n  = cap_q;
    if (start) begin
      busy_n = 1'b1;
      idx_n  = '0;
      sh_n   = {{PRE_LEN{1'b1}}, cmd};
      rd_n   = (cmd[CMD_W-3:CMD_W-4] == OP_READ);
      cap_n  = '0;
    end else if (busy_q) begin
      if (rise_tick && rd_q && (idx_q >= IDX_W'(DAT_IDX)))
        cap_n = {cap_q[DATA_W-2:0], mdio_i};
      if (fall_tick) begin
        if (last) begin
          busy_n = 1'b0;
        end else begin
          idx_n = idx_q + IDX_W'(1);
          sh_n  = {sh_q[FRAME_LEN-2:0], 1'b1};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '1;
      rd_q   <= 1'b0;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      rd_q   <= rd_n;
      cap_q  <= cap_n;
    end
  end

  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !fall_tick && !start |=> $stable(mdio_o));

  // R3
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && rd_q && rise_tick && (idx_q >= IDX_W'(DAT_IDX)) |-> !mdio_oe);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start));

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs #(
  parameter int SEL_W  = 2,
  parameter int CMD_W  = 32,
  parameter int DATA_W = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_sel,
  input  logic                              bus_wr,
  input  logic [mdio_mgmt_pkg::REG_AW-1:0]  bus_addr,
  input  logic [CMD_W-1:0]                  bus_wdata,
  output logic [CMD_W-1:0]                  bus_rdata,
  input  logic                              busy,
  input  logic                              done_pulse,
  input  logic                              is_read,
  input  logic [DATA_W-1:0]                 cap_data,
  input  logic                              mdio_pin,
  output logic                              start,
  output logic [SEL_W-1:0]                  div_sel
);

  import mdio_mgmt_pkg::*;

  logic             en_q, en_n;
  logic [SEL_W-1:0] cfg_q, cfg_n;
  logic [CMD_W-1:0] cmd_q, cmd_n;
  logic             irq_q, irq_n;
  logic             wr_en, rd_en;

  assign wr_en   = bus_sel & bus_wr;
  assign rd_en   = bus_sel & ~bus_wr;
  assign start   = wr_en & (bus_addr == RA_CMD) & en_q & ~busy;
  assign div_sel = cfg_q;

  always_comb begin
    en_n  = en_q;
    cfg_n = cfg_q;
    cmd_n = cmd_q;
    irq_n = irq_q;
    if (wr_en && bus_addr == RA_CTRL) en_n  = bus_wdata[0];
    if (wr_en && bus_addr == RA_CFG)  cfg_n = bus_wdata[SEL_W-1:0];
    if (start) cmd_n = bus_wdata;
    else if (done_pulse && is_read) cmd_n[DATA_W-1:0] = cap_data;
    if (done_pulse) irq_n = 1'b1;
    else if (rd_en && bus_addr == RA_IRQ) irq_n = 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_CTRL: bus_rdata[0]         = en_q;
      RA_CFG:  bus_rdata[SEL_W-1:0] = cfg_q;
      RA_STAT: bus_rdata[2:1]       = {~busy, mdio_pin};
      RA_IRQ:  bus_rdata[0]         = irq_q;
      RA_CMD:  bus_rdata            = cmd_q;
      default: bus_rdata            = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      cfg_q <= '0;
      cmd_q <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_n;
      cfg_q <= cfg_n;
      cmd_q <= cmd_n;
      irq_q <= irq_n;
    end
  end

  // R5
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> irq_q);

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done_pulse |=> $stable(cmd_q));

endmodule

// File: rtl/mdio_mgmt_top.sv
module mdio_mgmt_top #(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 3,
  parameter int PRE_LEN   = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int CMD_W  = 32;
  localparam int DATA_W = 16;

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  logic              start, busy, done_pulse, is_read;
  logic              rise_tick, fall_tick;
  logic [SEL_W-1:0]  div_sel;
  logic [DATA_W-1:0] cap_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  mdio_regs #(.SEL_W(SEL_W), .CMD_W(CMD_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(core_rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .done_pulse(done_pulse), .is_read(is_read),
    .cap_data(cap_data), .mdio_pin(mdio_i),
    .start(start), .div_sel(div_sel)
  );

  mdio_clk_gen #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) clk_i (
    .clk(clk), .rst_n(core_rst_n), .start(start), .run(busy),
    .div_sel(div_sel), .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .CMD_W(CMD_W), .DATA_W(DATA_W)) eng_i (
    .clk(clk), .rst_n(core_rst_n), .start(start), .cmd(bus_wdata),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .done_pulse(done_pulse), .is_read(is_read),
    .cap_data(cap_data), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !busy && !start |=> !mdio_oe && !mdc);

endmodule

// File: tb/mdio_mgmt_top_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_top_tb_top;

  import mdio_mgmt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_pin;

  logic        phy_en = 1'b0;
  logic        phy_o = 1'b1;
  logic        force_low = 1'b0;
  logic [15:0] phy_data = 16'd0;
  logic        cur_read = 1'b0;
  int unsigned base_cnt = 0;
  int unsigned rise_cnt = 0;
  int unsigned oe_err = 0;
  realtime     last_rise = 0.0;
  realtime     rise_period = 0.0;
  logic [63:0] frame_cap = 64'd0;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  assign mdio_pin = mdio_oe ? mdio_o : (phy_en ? phy_o : ~force_low);

  mdio_mgmt_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_pin)
  );

  // bench PHY: observe on rising edges, answer reads after falling edges
  always @(posedge mdc) begin
    int unsigned idx;
    logic exp_oe;
    idx = rise_cnt - base_cnt;
    frame_cap = {frame_cap[62:0], mdio_pin};
    exp_oe = !(cur_read && idx >= 46);
    if (idx < 64 && mdio_oe !== exp_oe) oe_err++;
    rise_period = $realtime - last_rise;
    last_rise = $realtime;
    rise_cnt++;
  end

  always @(negedge mdc) begin
    int unsigned idx;
    idx = rise_cnt - base_cnt;
    phy_en = 1'b0;
    if (cur_read) begin
      if (idx == 47) begin
        phy_en = 1'b1; phy_o = 1'b0;
      end else if (idx >= 48 && idx < 64) begin
        phy_en = 1'b1; phy_o = phy_data[63-idx];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end on a falling clock edge
  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  function automatic logic [31:0] make_cmd(input logic [1:0] op, input logic [4:0] pa,
                                           input logic [4:0] ra, input logic [15:0] wd);
    return 32'h4002_0000 | ({30'd0, op} << 28) | ({27'd0, pa} << 23) |
           ({27'd0, ra} << 18) | {16'd0, wd};
  endfunction

  function automatic logic [63:0] exp_frame(input logic [31:0] c, input logic [15:0] pd);
    if (c[29:28] == 2'b10) return {32'hFFFF_FFFF, c[31:18], 2'b10, pd};
    return {32'hFFFF_FFFF, c};
  endfunction

  function automatic logic [31:0] exp_cmd(input logic [31:0] c, input logic [15:0] pd);
    if (c[29:28] == 2'b10) return {c[31:16], pd};
    return c;
  endfunction

  task automatic run_txn(input logic [1:0] sel, input logic [1:0] op, input logic [4:0] pa,
                         input logic [4:0] ra, input logic [15:0] wd, input logic [15:0] pd);
    logic [31:0] c, d;
    int got, ones, limit, period;
    int unsigned oe_before;
    period = 8 << sel;
    limit  = 64 * period + 50;
    c = make_cmd(op, pa, ra, wd);
    bus_write(RA_CFG, {30'd0, sel});
    phy_data = pd;
    cur_read = (op == 2'b10);
    base_cnt = rise_cnt;
    oe_before = oe_err;
    bus_write(RA_CMD, c);
    got = -1; ones = 0;
    for (int i = 0; i < limit; i++) begin
      if (i == 1) begin
        bus_read(RA_STAT, d);
        check(d[2] == 1'b0, "R6 idle low while busy", {63'd0, d[2]}, 64'd0);
      end else if (i == 100) begin
        bus_write(RA_CMD, make_cmd(2'b01, ~pa, ~ra, ~wd));
      end else begin
        bus_read(RA_IRQ, d);
        if (d[0]) begin
          ones++;
          if (got < 0) got = i;
        end
        if (got >= 0 && i > got + 2) break;
      end
    end
    check(got == 64 * period, "R5 done timing", 64'(got), 64'(64 * period));
    check(ones == 1, "R5 done cleared by read", 64'(ones), 64'd1);
    bus_read(RA_STAT, d);
    check(d[2] == 1'b1, "R6 idle after done", {63'd0, d[2]}, 64'd1);
    bus_read(RA_CMD, d);
    check(d == exp_cmd(c, pd), cur_read ? "R3 R7 read result" : "R4 R7 write word kept",
          {32'd0, d}, {32'd0, exp_cmd(c, pd)});
    check(frame_cap == exp_frame(c, pd), "R2 frame content", frame_cap, exp_frame(c, pd));
    check(oe_err == oe_before, cur_read ? "R3 output enable" : "R4 output enable",
          64'(oe_err - oe_before), 64'd0);
    check(int'(rise_period) == 20 * period, "R1 mdc period",
          64'(int'(rise_period)), 64'(20 * period));
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R1 rest state", {62'd0, mdc, mdio_oe}, 64'd0);
    cur_read = 1'b0;
  endtask

  initial begin
    #3_900_000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int unsigned r0;
    void'($urandom(32'd20240611));
    #55 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    bus_read(RA_CTRL, d); check(d == 32'd0, "R9 ctrl reset", {32'd0, d}, 64'd0);
    bus_read(RA_CFG, d);  check(d == 32'd0, "R9 cfg reset", {32'd0, d}, 64'd0);
    bus_read(RA_IRQ, d);  check(d == 32'd0, "R9 irq reset", {32'd0, d}, 64'd0);
    bus_read(RA_STAT, d); check(d[2] == 1'b1, "R9 idle reset", {63'd0, d[2]}, 64'd1);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R9 pins reset", {62'd0, mdc, mdio_oe}, 64'd0);

    // R6 pin level while idle
    bus_read(RA_STAT, d); check(d[1] == 1'b1, "R6 pin high", {63'd0, d[1]}, 64'd1);
    force_low = 1'b1;
    bus_read(RA_STAT, d); check(d[1] == 1'b0, "R6 pin low", {63'd0, d[1]}, 64'd0);
    force_low = 1'b0;

    // R8 port disabled: command write starts nothing
    r0 = rise_cnt;
    bus_write(RA_CMD, make_cmd(2'b01, 5'd3, 5'd4, 16'h1234));
    for (int i = 0; i < 200; i++) begin
      if (mdio_oe !== 1'b0) begin
        check(1'b0, "R8 oe while disabled", 64'd1, 64'd0);
        break;
      end
      @(negedge clk);
    end
    check(rise_cnt == r0, "R8 no mdc while disabled", 64'(rise_cnt - r0), 64'd0);
    bus_read(RA_STAT, d); check(d[2] == 1'b1, "R8 idle while disabled", {63'd0, d[2]}, 64'd1);
    bus_read(RA_IRQ, d);  check(d[0] == 1'b0, "R8 no done while disabled", {63'd0, d[0]}, 64'd0);

    bus_write(RA_CTRL, 32'd1);

    // directed: every divider, both operations, extreme addresses and data
    run_txn(2'd0, 2'b10, 5'd31, 5'd0, 16'h0000, 16'hFFFF);
    run_txn(2'd1, 2'b01, 5'd0, 5'd31, 16'hFFFF, 16'h0000);
    run_txn(2'd2, 2'b10, 5'd1, 5'd1, 16'h5A5A, 16'h8001);
    run_txn(2'd3, 2'b01, 5'd17, 5'd9, 16'h0001, 16'h1234);

    // seeded random commands
    for (int k = 0; k < 8; k++) begin
      logic [1:0] sel, op;
      sel = 2'($urandom_range(0, 2));
      op  = ($urandom_range(0, 1) == 0) ? 2'b01 : 2'b10;
      run_txn(sel, op, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule